// File: doc/BRIEF.md
# Bit-Field Insert Execution Unit

This block is a 16-bit execution unit for a three-operand bit-field insert, meant to sit in the datapath of a small coprocessor. A request names three entries of an internal eight-entry register file: a target register, a data register and a control register. The control register holds, in its low byte, a width code and a bit offset. The unit takes the lowest width-code-plus-one bits of the data register and places them into the target register starting at the offset. Target bits outside that field are left as they were. Any part of the field that would land above bit 15 is dropped. The merged word is written back to the target register, and the N, Z, V and C flags are updated, in the same clock cycle.

Entry 0 of the register file is hard-wired to zero. Naming it as the data register therefore clears a field of the target. A separate host port can load any register, and a separate read port shows any register, so the file can be filled and inspected from outside the unit.

Top module: `bfi_unit`

## Requirements
- R1: The control register's bits 7:4 give the width code w, and its bits 3:0 give the offset o. Bits 15:8 of the control register have no effect on the result.
- R2: On a valid request, bits w:0 of the data register are copied into the target register at bit positions o+w down to o.
- R3: Target bits outside positions o+w..o keep their previous value.
- R4: When o+w > 15, data bits that would land above bit 15 are discarded. No other bit of the result changes because of them.
- R5: After a valid request, flag N equals bit 15 of the result, and flag Z is 1 exactly when the 16-bit result is 0x0000.
- R6: A valid request always clears flag V and leaves flag C unchanged.
- R7: Register 0 reads as 0x0000 on every read port, and writes to it are ignored. Using register 0 as the data register clears the addressed field of the target.
- R8: The result and the flags take effect on the rising clock edge after a cycle with `req_valid` high. In a cycle with `req_valid` low, no register and no flag changes.
- R9: A synchronous reset (`rst` high at a rising edge) clears all eight registers and all four flags to zero.
- R10: With `ld_en` high, `ld_data` is written into register `ld_idx` at the next rising edge. If a valid request targets the same register in the same cycle, the request's result wins. `rd_data` shows register `rd_idx` combinationally.
- R11: All three operands are read before the edge. A request may name the same register for two or three operands, and it uses that register's old value for each of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Insert request valid for this cycle |
| req_dst | input | 3 | Target register index |
| req_src | input | 3 | Data register index |
| req_ctl | input | 3 | Control register index |
| ld_en | input | 1 | Host register write enable |
| ld_idx | input | 3 | Host write register index |
| ld_data | input | 16 | Host write data |
| rd_idx | input | 3 | Host read register index |
| rd_data | output | 16 | Contents of register rd_idx |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench aims at several edge cases:
- The full-width code (w=15). A mask built with a 4-bit width counter wraps here and inserts nothing.
- Offset-plus-width sums past bit 15. A design that does not truncate corrupts bits or wraps them around to the bottom of the word.
- Control words with junk in the high byte. A design that decodes too many bits picks the wrong field.
- Register 0 used as target and as data. A design that stores into it makes later reads nonzero, and one that reads it from storage fails to clear the field.
- Idle cycles with busy indices, and a load and an insert to the same register in one cycle. A design with wrong enable gating or priority leaves the wrong value behind.
- Requests that alias operands, and results that are zero or negative. These expose a design that reads operands after the write or derives N or Z from the wrong word.

// File: rtl/bfi_pkg.sv
package bfi_pkg;

    parameter int DATA_W = 16;
    parameter int NREGS  = 8;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } bfi_flags_t;

endpackage

// File: rtl/bfi_field.sv
module bfi_field #(
    parameter int DATA_W = 16,
    localparam int OFS_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  dst,
    input  logic [DATA_W-1:0]  src,
    input  logic [2*OFS_W-1:0] ctl,
    output logic [DATA_W-1:0]  result,
    output logic [DATA_W-1:0]  mask
);

    logic [OFS_W-1:0]  wcode;
    logic [OFS_W-1:0]  ofs;
    logic [OFS_W:0]    run_len;
    logic [DATA_W-1:0] run_ones;

    always_comb begin
        wcode    = ctl[2*OFS_W-1:OFS_W];
        ofs      = ctl[OFS_W-1:0];
        // one more bit than the width code; the extra bit keeps the full-width case from wrapping
        run_len  = {1'b0, wcode} + {{OFS_W{1'b0}}, 1'b1};
        // a shift by the full word width empties the word, so inverting gives all ones
        run_ones = ~({DATA_W{1'b1}} << run_len);
        // bits pushed past the top of the word simply fall off
        mask     = run_ones << ofs;
        result   = (dst & ~mask) | ((src << ofs) & mask);
    end

endmodule

// File: rtl/bfi_regfile.sv
module bfi_regfile #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8,
    parameter int NRD    = 4,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NRD*IDX_W-1:0]  rd_idx,
    output logic [NRD*DATA_W-1:0] rd_data,
    input  logic                  op_we,
    input  logic [IDX_W-1:0]      op_idx,
    input  logic [DATA_W-1:0]     op_data,
    input  logic                  ld_we,
    input  logic [IDX_W-1:0]      ld_idx,
    input  logic [DATA_W-1:0]     ld_data
);

    logic [DATA_W-1:0] regs_d [NREGS];
    logic [DATA_W-1:0] regs_q [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (ld_we) begin
            regs_d[ld_idx] = ld_data;
        end
        // the insert result takes priority over a host load to the same entry
        if (op_we) begin
            regs_d[op_idx] = op_data;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [IDX_W-1:0] idx_p;
        assign idx_p = rd_idx[p*IDX_W +: IDX_W];
        assign rd_data[p*DATA_W +: DATA_W] = (idx_p == '0) ? '0 : regs_q[idx_p];

        AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
            (idx_p == '0) |-> (rd_data[p*DATA_W +: DATA_W] == '0)); // R7
    end

    AST_OP_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_we && op_idx != '0) |=> (regs_q[$past(op_idx)] == $past(op_data))); // R8

    AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ld_we && !(op_we && op_idx == ld_idx) && ld_idx != '0)
        |=> (regs_q[$past(ld_idx)] == $past(ld_data))); // R10

endmodule

// File: rtl/bfi_unit.sv
module bfi_unit
    import bfi_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int NR  = NREGS,
    localparam int IW = $clog2(NR),
    localparam int OW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [IW-1:0] req_dst,
    input  logic [IW-1:0] req_src,
    input  logic [IW-1:0] req_ctl,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);

    localparam int NPORT = 4;

    bfi_flags_t flags_d, flags_q;

    logic [NPORT*DW-1:0] port_data;
    logic [DW-1:0]       dst_val, src_val, ctl_val;
    logic [DW-1:0]       ins_result, ins_mask;
    logic [DW-1:0]       unused_ctl_hi;

    // read ports, lowest first: target, data, control, host
    bfi_regfile #(.DATA_W(DW), .NREGS(NR), .NRD(NPORT)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  ({rd_idx, req_ctl, req_src, req_dst}),
        .rd_data (port_data),
        .op_we   (req_valid),
        .op_idx  (req_dst),
        .op_data (ins_result),
        .ld_we   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data)
    );

    assign dst_val = port_data[0*DW +: DW];
    assign src_val = port_data[1*DW +: DW];
    assign ctl_val = port_data[2*DW +: DW];
    assign rd_data = port_data[3*DW +: DW];

    // only the low byte of the control word is decoded
    assign unused_ctl_hi = {{(2*OW){1'b0}}, ctl_val[DW-1:2*OW]};

    bfi_field #(.DATA_W(DW)) u_field (
        .dst    (dst_val),
        .src    (src_val),
        .ctl    (ctl_val[2*OW-1:0]),
        .result (ins_result),
        .mask   (ins_mask)
    );

    always_comb begin
        flags_d = flags_q;
        if (req_valid) begin
            flags_d.n = ins_result[DW-1];
            flags_d.z = (ins_result == '0);
            flags_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_c = flags_q.c;

    AST_KEEP_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (((ins_result ^ dst_val) & ~ins_mask) == '0)); // R3
    AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (flag_n == $past(ins_result[DW-1]))); // R5
    AST_V_CLEARED: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !flag_v); // R6
    AST_C_HELD: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> $stable(flag_c)); // R6
    AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(flags_q)); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (flags_q == '0)); // R9

endmodule

// File: tb/bfi_unit_test.sv
`timescale 1ns/100ps
module bfi_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_dst = '0, req_src = '0, req_ctl = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [15:0] ld_data = '0;
    logic [2:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_reg [8];
    logic        m_n, m_z, m_v, m_c;

    always #2.5 clk = ~clk;

    bfi_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_dst(req_dst), .req_src(req_src), .req_ctl(req_ctl),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    function automatic logic [15:0] model_insert(logic [15:0] d, logic [15:0] s, logic [15:0] c);
        int w = int'(c[7:4]);
        int o = int'(c[3:0]);
        logic [15:0] r = d;
        for (int k = 0; k <= w; k++) begin
            if (o + k < 16) r[o+k] = s[k];
        end
        return r;
    endfunction

    task automatic check_bit(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_state(string tag);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.2;
            checks++;
            if (rd_data !== m_reg[i]) begin
                errors++;
                $display("FAIL %s reg%0d actual=%h expected=%h", tag, i, rd_data, m_reg[i]);
            end
        end
        check_bit(tag, "N", flag_n, m_n);
        check_bit(tag, "Z", flag_z, m_z);
        check_bit(tag, "V", flag_v, m_v);
        check_bit(tag, "C", flag_c, m_c);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_n = 0; m_z = 0; m_v = 0; m_c = 0;
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #0.5 rst = 1'b0;
        model_reset();
        check_state(tag);
    endtask

    // optional simultaneous host load; insert wins on equal index
    task automatic do_cycle(string tag, bit v, int d, int s, int c, bit l, int li, logic [15:0] ldat);
        logic [15:0] res;
        @(negedge clk);
        req_valid = v; req_dst = 3'(d); req_src = 3'(s); req_ctl = 3'(c);
        ld_en = l; ld_idx = 3'(li); ld_data = ldat;
        res = model_insert(m_reg[d], m_reg[s], m_reg[c]);
        @(posedge clk);
        #0.5;
        req_valid = 1'b0; ld_en = 1'b0;
        if (l && li != 0) m_reg[li] = ldat;
        if (v) begin
            if (d != 0) m_reg[d] = res;
            m_n = res[15];
            m_z = (res == 16'h0000);
            m_v = 1'b0;
        end
        check_state(tag);
    endtask

    task automatic do_load(string tag, int idx, logic [15:0] val);
        do_cycle(tag, 1'b0, 0, 0, 0, 1'b1, idx, val);
    endtask

    task automatic do_op(string tag, int d, int s, int c);
        do_cycle(tag, 1'b1, d, s, c, 1'b0, 0, 16'h0000);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R9: state after the initial reset
        @(posedge clk);
        #0.5 rst = 1'b0;
        check_state("R9");

        // R10: host loads, read back through the read port
        do_load("R10", 1, 16'hA5C3);
        do_load("R10", 2, 16'h00B5);   // w=11, o=5
        do_load("R10", 3, 16'h1234);
        do_load("R10", 4, 16'h00F0);   // w=15, o=0
        do_load("R10", 5, 16'h007C);   // w=7, o=12: runs past bit 15
        do_load("R10", 6, 16'hFF32);   // junk high byte, w=3, o=2
        do_load("R10", 7, 16'h0032);   // same low byte, clean high byte

        // R7: a load to register 0 is ignored
        do_load("R7", 0, 16'hFFFF);

        // R2 R3: plain insert
        do_op("R2", 3, 1, 2);
        // R2: full width code copies the whole word
        do_op("R2", 1, 3, 4);
        // R4: field truncated at the top
        do_op("R4", 3, 1, 5);
        // R1: high control byte ignored, compared against clean copy
        do_load("R1", 3, 16'hFFFF);
        do_op("R1", 3, 1, 6);
        do_load("R1", 1, 16'hFFFF);
        do_op("R1", 1, 2, 7);
        // R7: data from register 0 clears the field
        do_op("R7", 3, 0, 2);
        // R7: register 0 as target is not written, flags still update
        do_op("R7", 0, 1, 4);
        // R5: zero result sets Z
        do_load("R5", 3, 16'h0000);
        do_op("R5", 3, 0, 4);
        // R5 R6: negative result sets N, clears V, C holds
        do_op("R6", 3, 1, 4);
        // R8: idle cycles with busy indices change nothing
        do_cycle("R8", 1'b0, 3, 0, 4, 1'b0, 0, 16'h0000);
        do_cycle("R8", 1'b0, 2, 1, 5, 1'b0, 0, 16'h0000);
        // R10: load and insert to same register, insert wins
        do_cycle("R10", 1'b1, 6, 1, 2, 1'b1, 6, 16'h5555);
        // R10: load and insert to different registers both land
        do_cycle("R10", 1'b1, 7, 1, 2, 1'b1, 3, 16'h3C3C);
        // R11: aliased operands use pre-edge values
        do_op("R11", 2, 2, 2);
        do_op("R11", 5, 5, 4);
        do_op("R11", 3, 1, 3);

        // R2 R3 R4 R5: pseudo-random mix
        for (int n = 0; n < 300; n++) begin
            int sel = int'($urandom_range(0, 9));
            if (sel < 3) begin
                do_load("R10", int'($urandom_range(0, 7)), 16'($urandom));
            end else if (sel < 4) begin
                do_cycle("R8", 1'b0, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                         int'($urandom_range(0, 7)), 1'b0, 0, 16'h0000);
            end else begin
                do_op("R2", int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                      int'($urandom_range(0, 7)));
            end
        end

        // R9: reset in the middle of activity
        do_reset("R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule